// File: doc/BRIEF.md
# Banked MSI Doorbell Interrupt Aggregator

This block collects message-signalled interrupts and four emulated level interrupt lines and merges them into a single interrupt request for the processor's interrupt controller. Inbound memory writes arrive on a doorbell port as an address and a 32-bit data word. Each of eight banks owns a programmable doorbell address. A write that hits an enabled bank's address marks one of that bank's 32 vectors as pending, and the write data selects the vector.

The interrupt tree has two levels. Each bank keeps a 32-bit pending register that software clears by writing ones, and a 32-bit vector mask. When a bank has a pending vector that is also unmasked, it raises a summary line. The summary lines and the four legacy line states feed a top-level status register, which also clears by writing ones. A top-level enable register gates that status onto the output. The legacy lines are driven by assert and deassert pulse inputs. Each line holds its status bit until its deassert pulse has arrived and software has cleared the bit.

Software reaches every register through a plain register port: a write strobe, an address, write data, and read data that follows the address combinationally. Doorbell writes that cannot be delivered set a sticky error flag.

Top module: `msi_irq_aggregator`

## Requirements
- R1: After reset, every register reads zero, `irqOut` is 0 and `errFlag` is 0.
- R2: A doorbell write lands in bank i when bank i is enabled and its address register (offset 0xC00 + 0x10*i) equals `dbAddr`. It sets bit `dbData` of that bank's pending register (offset 0xC04 + 0x10*i), and the bit is readable after the clock edge that samples the doorbell.
- R3: Writing a word to a bank's pending register clears each bit that is 1 in the word. Bits written as 0 keep their value.
- R4: Bank i's summary is the OR of (pending AND mask), where the mask sits at offset 0xC08 + 0x10*i. Top status bit 8+i (offset 0x184) sets one cycle after the summary goes high. A write of 1 clears that bit only when the summary is low; while the summary stays high, the bit stays set.
- R5: The top enable register (offset 0x180) holds only bits 8 to 15 and bits 24 to 27. All other bits read as 0 whatever is written.
- R6: `irqOut` is 1 exactly one cycle after some bit is set in both top status and top enable. It is 0 one cycle after no such bit exists.
- R7: A doorbell aimed at a bank whose bit i in the bank-enable register (offset 0x190) is 0 changes no pending bit.
- R8: A doorbell is dropped when its data is 32 or more, or when its address matches no enabled bank. A dropped doorbell sets `errFlag`, which stays 1 until reset.
- R9: An assert pulse on `intxAssert[k]` makes the line level high. Top status bit 24+k sets one cycle later. That bit survives a write of 1 while the level is high, and stays set after a deassert pulse until software writes 1 to it.
- R10: When a doorbell sets a vector in the same cycle that software clears the same vector, the vector stays pending.
- R11: When two enabled banks hold the same doorbell address, only the lower-numbered bank receives the doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` |
| dbValid | input | 1 | Doorbell write valid |
| dbAddr | input | 32 | Doorbell write address |
| dbData | input | 32 | Doorbell write data (vector index) |
| intxAssert | input | 4 | Per-line assert message pulses |
| intxDeassert | input | 4 | Per-line deassert message pulses |
| irqOut | output | 1 | Combined registered interrupt request |
| errFlag | output | 1 | Sticky dropped-doorbell flag |

## Verification
The bench rings every one of the 256 vectors and checks that exactly the addressed bit appears and then clears. A wrong vector decode or bank select would therefore show up as a stray or missing bit. It clears a top status bit while a bank's unmasked vector is still pending. A design that treated the summary as an edge would lose that interrupt. It also collides a doorbell with a software clear of the same vector, where clear-wins ordering would drop the interrupt. It aims a doorbell at two banks that share one address, where a missing priority would set both. Finally, it checks that a legacy line keeps its status across a clear while asserted and after deassertion until it is cleared again. It also checks that out-of-range data and unmatched addresses raise the sticky flag without touching any pending bit.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int NUM_BANKS     = 8;
  localparam int VEC_PER_BANK  = 32;
  localparam int NUM_INTX      = 4;
  localparam int REG_AW        = 12;
  localparam int DB_AW         = 32;
  localparam int DW            = 32;
  localparam int BANK_IDX_W    = $clog2(NUM_BANKS);
  localparam int VEC_IDX_W     = $clog2(VEC_PER_BANK);
  localparam int STRIDE_LOG2   = 4;
  localparam int MSI_SHIFT     = 8;
  localparam int INTX_SHIFT    = 24;

  localparam logic [REG_AW-1:0] TOP_EN_ADDR   = 12'h180;
  localparam logic [REG_AW-1:0] TOP_STAT_ADDR = 12'h184;
  localparam logic [REG_AW-1:0] BANK_EN_ADDR  = 12'h190;
  localparam logic [REG_AW-1:0] BANK_BASE     = 12'hC00;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TOP_EN,
    SEL_TOP_STAT,
    SEL_BANK_EN,
    SEL_BANK_ADDR,
    SEL_BANK_STAT,
    SEL_BANK_MASK
  } regSel_e;

  typedef struct packed {
    regSel_e                sel;
    logic [BANK_IDX_W-1:0]  bankSel;
    logic                   topEnWr;
    logic                   topStatWr;
    logic                   bankEnWr;
    logic                   bankAddrWr;
    logic                   bankStatWr;
    logic                   bankMaskWr;
    logic [DW-1:0]          wdata;
  } regStrobe_t;
endpackage

// File: rtl/msi_agg_bank.sv
module msi_agg_bank #(
  parameter int VEC_PER_BANK = msi_agg_pkg::VEC_PER_BANK,
  parameter int DB_AW        = msi_agg_pkg::DB_AW,
  parameter int DW           = msi_agg_pkg::DW,
  localparam int VEC_IDX_W   = $clog2(VEC_PER_BANK)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    addrWr,
  input  logic                    maskWr,
  input  logic                    statWr,
  input  logic [DW-1:0]           wdata,
  input  logic                    setEn,
  input  logic [VEC_IDX_W-1:0]    setIdx,
  output logic [DB_AW-1:0]        doorbellAddr,
  output logic [VEC_PER_BANK-1:0] pend,
  output logic [VEC_PER_BANK-1:0] mask,
  output logic                    summary
);
  logic [VEC_PER_BANK-1:0] clrVec;
  logic [VEC_PER_BANK-1:0] setVec;

  always_comb begin
    clrVec = statWr ? wdata[VEC_PER_BANK-1:0] : '0;
    setVec = '0;
    if (setEn) setVec[setIdx] = 1'b1;
  end

  // a new doorbell outranks a software clear of the same vector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doorbellAddr <= '0;
      pend         <= '0;
      mask         <= '0;
    end else begin
      if (addrWr) doorbellAddr <= wdata[DB_AW-1:0];
      if (maskWr) mask <= wdata[VEC_PER_BANK-1:0];
      pend <= (pend & ~clrVec) | setVec;
    end
  end

  assign summary = |(pend & mask);
endmodule

// File: rtl/msi_agg_ctrl.sv
module msi_agg_ctrl
  import msi_agg_pkg::*;
#(
  parameter int NUM_BANKS = msi_agg_pkg::NUM_BANKS
) (
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DW-1:0]     regWdata,
  output regStrobe_t        strobe
);
  localparam int BANK_LO = int'(BANK_BASE);
  localparam int BANK_HI = BANK_LO + (NUM_BANKS << STRIDE_LOG2);

  regSel_e                sel;
  logic                   inBankWin;
  logic [STRIDE_LOG2-1:0] sub;

  assign inBankWin = (int'(regAddr) >= BANK_LO) && (int'(regAddr) < BANK_HI);
  assign sub       = regAddr[STRIDE_LOG2-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (regAddr == TOP_EN_ADDR)        sel = SEL_TOP_EN;
    else if (regAddr == TOP_STAT_ADDR) sel = SEL_TOP_STAT;
    else if (regAddr == BANK_EN_ADDR)  sel = SEL_BANK_EN;
    else if (inBankWin) begin
      case (sub)
        4'h0:    sel = SEL_BANK_ADDR;
        4'h4:    sel = SEL_BANK_STAT;
        4'h8:    sel = SEL_BANK_MASK;
        default: sel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.sel        = sel;
    strobe.bankSel    = regAddr[STRIDE_LOG2 +: BANK_IDX_W];
    strobe.wdata      = regWdata;
    strobe.topEnWr    = regWe && (sel == SEL_TOP_EN);
    strobe.topStatWr  = regWe && (sel == SEL_TOP_STAT);
    strobe.bankEnWr   = regWe && (sel == SEL_BANK_EN);
    strobe.bankAddrWr = regWe && (sel == SEL_BANK_ADDR);
    strobe.bankStatWr = regWe && (sel == SEL_BANK_STAT);
    strobe.bankMaskWr = regWe && (sel == SEL_BANK_MASK);
  end
endmodule

// File: rtl/msi_agg_datapath.sv
module msi_agg_datapath
  import msi_agg_pkg::*;
#(
  parameter int NUM_BANKS    = msi_agg_pkg::NUM_BANKS,
  parameter int VEC_PER_BANK = msi_agg_pkg::VEC_PER_BANK,
  parameter int NUM_INTX     = msi_agg_pkg::NUM_INTX,
  parameter int DB_AW        = msi_agg_pkg::DB_AW,
  localparam int VEC_IDX_W   = $clog2(VEC_PER_BANK),
  localparam int PEND_W      = NUM_BANKS * VEC_PER_BANK
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic                 dbValid,
  input  logic [DB_AW-1:0]     dbAddr,
  input  logic [DW-1:0]        dbData,
  input  logic [NUM_INTX-1:0]  intxAssert,
  input  logic [NUM_INTX-1:0]  intxDeassert,
  output logic [DW-1:0]        regRdata,
  output logic                 irqOut,
  output logic                 errFlag,
  output logic [DW-1:0]        topStatQ,
  output logic [DW-1:0]        topEnQ,
  output logic [NUM_INTX-1:0]  intxLevelQ,
  output logic [PEND_W-1:0]    pendAll
);
  localparam logic [DW-1:0] TOP_MASK =
      (DW'((1 << NUM_BANKS) - 1) << MSI_SHIFT) |
      (DW'((1 << NUM_INTX) - 1) << INTX_SHIFT);

  logic [DB_AW-1:0]        bankAddr [NUM_BANKS];
  logic [VEC_PER_BANK-1:0] bankPend [NUM_BANKS];
  logic [VEC_PER_BANK-1:0] bankMask [NUM_BANKS];
  logic [NUM_BANKS-1:0]    bankSum;
  logic [NUM_BANKS-1:0]    bankEn;
  logic [NUM_BANKS-1:0]    bankMatch;
  logic [NUM_BANKS-1:0]    bankHit;
  logic                    idxOk;
  logic                    dbAccept;
  logic [DW-1:0]           topSrc;
  logic [DW-1:0]           topClr;

  assign idxOk    = dbData < DW'(VEC_PER_BANK);
  // isolate the lowest matching bank
  assign bankHit  = bankMatch & (~bankMatch + NUM_BANKS'(1));
  assign dbAccept = dbValid && idxOk && (|bankMatch);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign bankMatch[i] = bankEn[i] && (bankAddr[i] == dbAddr);
    assign pendAll[i*VEC_PER_BANK +: VEC_PER_BANK] = bankPend[i];

    msi_agg_bank #(
      .VEC_PER_BANK(VEC_PER_BANK),
      .DB_AW       (DB_AW),
      .DW          (DW)
    ) u_bank (
      .clk         (clk),
      .rstN        (rstN),
      .addrWr      (strobe.bankAddrWr && (strobe.bankSel == BANK_IDX_W'(i))),
      .maskWr      (strobe.bankMaskWr && (strobe.bankSel == BANK_IDX_W'(i))),
      .statWr      (strobe.bankStatWr && (strobe.bankSel == BANK_IDX_W'(i))),
      .wdata       (strobe.wdata),
      .setEn       (dbAccept && bankHit[i]),
      .setIdx      (dbData[VEC_IDX_W-1:0]),
      .doorbellAddr(bankAddr[i]),
      .pend        (bankPend[i]),
      .mask        (bankMask[i]),
      .summary     (bankSum[i])
    );
  end

  always_comb begin
    topSrc = '0;
    topSrc[MSI_SHIFT +: NUM_BANKS] = bankSum;
    topSrc[INTX_SHIFT +: NUM_INTX] = intxLevelQ;
    topClr = strobe.topStatWr ? strobe.wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topStatQ   <= '0;
      topEnQ     <= '0;
      bankEn     <= '0;
      intxLevelQ <= '0;
      irqOut     <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      // status re-latches from the live sources every cycle
      topStatQ   <= ((topStatQ & ~topClr) | topSrc) & TOP_MASK;
      if (strobe.topEnWr)  topEnQ <= strobe.wdata & TOP_MASK;
      if (strobe.bankEnWr) bankEn <= strobe.wdata[NUM_BANKS-1:0];
      intxLevelQ <= (intxLevelQ & ~intxDeassert) | intxAssert;
      irqOut     <= |(topStatQ & topEnQ);
      if (dbValid && !dbAccept) errFlag <= 1'b1;
    end
  end

  always_comb begin
    regRdata = '0;
    case (strobe.sel)
      SEL_TOP_EN:    regRdata = topEnQ;
      SEL_TOP_STAT:  regRdata = topStatQ;
      SEL_BANK_EN:   regRdata[NUM_BANKS-1:0] = bankEn;
      SEL_BANK_ADDR: regRdata[DB_AW-1:0] = bankAddr[strobe.bankSel];
      SEL_BANK_STAT: regRdata[VEC_PER_BANK-1:0] = bankPend[strobe.bankSel];
      SEL_BANK_MASK: regRdata[VEC_PER_BANK-1:0] = bankMask[strobe.bankSel];
      default:       regRdata = '0;
    endcase
  end
endmodule

// File: rtl/msi_irq_aggregator.sv
module msi_irq_aggregator
  import msi_agg_pkg::*;
#(
  parameter int NUM_BANKS    = msi_agg_pkg::NUM_BANKS,
  parameter int VEC_PER_BANK = msi_agg_pkg::VEC_PER_BANK,
  parameter int NUM_INTX     = msi_agg_pkg::NUM_INTX,
  parameter int ADDR_W       = msi_agg_pkg::REG_AW,
  parameter int DBA_W        = msi_agg_pkg::DB_AW,
  parameter int DATA_W       = msi_agg_pkg::DW,
  localparam int PEND_W      = NUM_BANKS * VEC_PER_BANK
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic                dbValid,
  input  logic [DBA_W-1:0]    dbAddr,
  input  logic [DATA_W-1:0]   dbData,
  input  logic [NUM_INTX-1:0] intxAssert,
  input  logic [NUM_INTX-1:0] intxDeassert,
  output logic                irqOut,
  output logic                errFlag
);
  regStrobe_t          strobe;
  logic [DATA_W-1:0]   topStatQ;
  logic [DATA_W-1:0]   topEnQ;
  logic [NUM_INTX-1:0] intxLevelQ;
  logic [PEND_W-1:0]   pendAll;

  msi_agg_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .strobe  (strobe)
  );

  msi_agg_datapath #(
    .NUM_BANKS   (NUM_BANKS),
    .VEC_PER_BANK(VEC_PER_BANK),
    .NUM_INTX    (NUM_INTX),
    .DB_AW       (DBA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .dbValid     (dbValid),
    .dbAddr      (dbAddr),
    .dbData      (dbData),
    .intxAssert  (intxAssert),
    .intxDeassert(intxDeassert),
    .regRdata    (regRdata),
    .irqOut      (irqOut),
    .errFlag     (errFlag),
    .topStatQ    (topStatQ),
    .topEnQ      (topEnQ),
    .intxLevelQ  (intxLevelQ),
    .pendAll     (pendAll)
  );
endmodule

// File: rtl/msi_agg_checker.sv
module msi_agg_checker #(
  parameter int NUM_BANKS    = 8,
  parameter int VEC_PER_BANK = 32,
  parameter int NUM_INTX     = 4,
  parameter int DATA_W       = 32,
  parameter int INTX_POS     = 24,
  localparam int PEND_W      = NUM_BANKS * VEC_PER_BANK
) (
  input logic                clk,
  input logic                rstN,
  input logic                dbValid,
  input logic [DATA_W-1:0]   dbData,
  input logic                irqOut,
  input logic                errFlag,
  input logic [DATA_W-1:0]   topStatQ,
  input logic [DATA_W-1:0]   topEnQ,
  input logic [NUM_INTX-1:0] intxLevelQ,
  input logic [PEND_W-1:0]   pendAll
);
  // R8: once raised the error flag never drops
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R8: out-of-range vector data raises the flag
  p_bad_idx_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dbValid && (dbData >= DATA_W'(VEC_PER_BANK))) |=> errFlag);

  // R6: nothing enabled and pending means no request next cycle
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(|(topStatQ & topEnQ)) |=> !irqOut);

  // R2: pending bits only grow after a doorbell
  p_pend_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(pendAll) > $countones($past(pendAll))) |-> $past(dbValid));

  // R9: a high line level shows in top status next cycle
  for (genvar k = 0; k < NUM_INTX; k++) begin : g_intx
    p_intx_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      intxLevelQ[k] |=> topStatQ[INTX_POS + k]);
  end
endmodule

bind msi_irq_aggregator msi_agg_checker #(
  .NUM_BANKS   (NUM_BANKS),
  .VEC_PER_BANK(VEC_PER_BANK),
  .NUM_INTX    (NUM_INTX),
  .DATA_W      (DATA_W),
  .INTX_POS    (msi_agg_pkg::INTX_SHIFT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dbValid   (dbValid),
  .dbData    (dbData),
  .irqOut    (irqOut),
  .errFlag   (errFlag),
  .topStatQ  (topStatQ),
  .topEnQ    (topEnQ),
  .intxLevelQ(intxLevelQ),
  .pendAll   (pendAll)
);

// File: tb/tb_msi_irq_aggregator.sv
module tb_msi_irq_aggregator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        dbValid = 1'b0;
  logic [31:0] dbAddr = '0;
  logic [31:0] dbData = '0;
  logic [3:0]  intxAssert = '0;
  logic [3:0]  intxDeassert = '0;
  logic        irqOut;
  logic        errFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  msi_irq_aggregator dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .dbValid(dbValid),
    .dbAddr(dbAddr), .dbData(dbData), .intxAssert(intxAssert),
    .intxDeassert(intxDeassert), .irqOut(irqOut), .errFlag(errFlag)
  );

  function automatic logic [31:0] dbOf(int b);
    return 32'hFE00_0000 + 32'(b) * 32'h100;
  endfunction
  function automatic logic [11:0] bankReg(int b, int off);
    return 12'hC00 + 12'(b * 16 + off);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic ring(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    dbValid = 1'b1; dbAddr = a; dbData = d;
    @(negedge clk);
    dbValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
  endtask

  task automatic setupBanks();
    for (int b = 0; b < 8; b++) begin
      wr(bankReg(b, 0), dbOf(b));
      wr(bankReg(b, 8), 32'hFFFF_FFFF);
    end
    wr(12'h190, 32'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    tick(); tick();
    rstN = 1'b1;
    tick();

    // R1: reset state
    rd(12'h180, v); chk("R1 top enable", v, 0);
    rd(12'h184, v); chk("R1 top status", v, 0);
    rd(12'h190, v); chk("R1 bank enable", v, 0);
    for (int b = 0; b < 8; b++) begin
      rd(bankReg(b, 0), v); chk("R1 bank addr", v, 0);
      rd(bankReg(b, 4), v); chk("R1 bank pend", v, 0);
      rd(bankReg(b, 8), v); chk("R1 bank mask", v, 0);
    end
    chk("R1 irqOut", 32'(irqOut), 0);
    chk("R1 errFlag", 32'(errFlag), 0);

    // R5: only summary and line bits are writable
    wr(12'h180, 32'hFFFF_FFFF);
    rd(12'h180, v); chk("R5 top enable mask", v, 32'h0F00_FF00);
    wr(12'h180, 32'h00F0_00F0);
    rd(12'h180, v); chk("R5 reserved bits", v, 0);
    wr(12'h180, 32'hFFFF_FFFF);

    setupBanks();
    rd(bankReg(3, 0), v); chk("R2 addr readback", v, dbOf(3));

    // R2/R3/R4/R6: full sweep of every vector in every bank
    for (int b = 0; b < 8; b++) begin
      for (int vec = 0; vec < 32; vec++) begin
        ring(dbOf(b), 32'(vec));
        rd(bankReg(b, 4), v); chk("R2 pend set", v, 32'h1 << vec);
        if (vec == 0) begin
          tick();
          rd(12'h184, v); chk("R4 top summary", v, 32'h1 << (8 + b));
          tick();
          chk("R6 irq raised", 32'(irqOut), 1);
        end
        if (vec == 5) begin
          wr(bankReg(b, 4), 32'h0);
          rd(bankReg(b, 4), v); chk("R3 write zero no effect", v, 32'h1 << vec);
        end
        wr(bankReg(b, 4), 32'h1 << vec);
        rd(bankReg(b, 4), v); chk("R3 pend cleared", v, 0);
      end
      wr(12'h184, 32'h1 << (8 + b));
      rd(12'h184, v); chk("R4 top cleared", v, 0);
      tick();
      chk("R6 irq dropped", 32'(irqOut), 0);
    end
    chk("R8 no spurious error", 32'(errFlag), 0);

    // R11: duplicate address goes to the lower bank
    wr(bankReg(5, 0), dbOf(2));
    ring(dbOf(2), 32'd7);
    rd(bankReg(2, 4), v); chk("R11 low bank takes", v, 32'h80);
    rd(bankReg(5, 4), v); chk("R11 high bank untouched", v, 0);
    wr(bankReg(2, 4), 32'h80);
    wr(bankReg(5, 0), dbOf(5));
    wr(12'h184, 32'hFFFF_FFFF);

    // R10: set and clear of the same vector in one cycle
    ring(dbOf(0), 32'd9);
    @(negedge clk);
    dbValid = 1'b1; dbAddr = dbOf(0); dbData = 32'd9;
    regWe = 1'b1; regAddr = bankReg(0, 4); regWdata = 32'h200;
    @(negedge clk);
    dbValid = 1'b0; regWe = 1'b0;
    rd(bankReg(0, 4), v); chk("R10 set wins", v, 32'h200);
    @(negedge clk);
    dbValid = 1'b1; dbAddr = dbOf(0); dbData = 32'd10;
    regWe = 1'b1; regAddr = bankReg(0, 4); regWdata = 32'h200;
    @(negedge clk);
    dbValid = 1'b0; regWe = 1'b0;
    rd(bankReg(0, 4), v); chk("R10 other vector cleared", v, 32'h400);
    wr(bankReg(0, 4), 32'hFFFF_FFFF);
    wr(12'h184, 32'hFFFF_FFFF);
    rd(12'h184, v); chk("R4 all clear", v, 0);

    // R4/R6: masking and level re-latch
    wr(bankReg(1, 8), 32'h0);
    ring(dbOf(1), 32'd4);
    tick(); tick();
    rd(12'h184, v); chk("R4 masked no summary", v, 0);
    chk("R6 masked no irq", 32'(irqOut), 0);
    wr(bankReg(1, 8), 32'h10);
    tick();
    rd(12'h184, v); chk("R4 unmask summary", v, 32'h200);
    wr(12'h184, 32'h200);
    rd(12'h184, v); chk("R4 clear while pending", v, 32'h200);
    wr(12'h180, 32'h0);
    tick();
    chk("R6 disabled no irq", 32'(irqOut), 0);
    wr(bankReg(1, 4), 32'h10);
    wr(12'h184, 32'h200);
    rd(12'h184, v); chk("R4 clear after pend gone", v, 0);
    wr(12'h180, 32'hFFFF_FFFF);
    wr(bankReg(1, 8), 32'hFFFF_FFFF);

    // R9: legacy lines
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); intxAssert[k] = 1'b1;
      @(negedge clk); intxAssert[k] = 1'b0;
      tick();
      rd(12'h184, v); chk("R9 line status set", v, 32'h1 << (24 + k));
      wr(12'h184, 32'h1 << (24 + k));
      rd(12'h184, v); chk("R9 clear while asserted", v, 32'h1 << (24 + k));
      @(negedge clk); intxDeassert[k] = 1'b1;
      @(negedge clk); intxDeassert[k] = 1'b0;
      tick();
      rd(12'h184, v); chk("R9 held after deassert", v, 32'h1 << (24 + k));
      wr(12'h184, 32'h1 << (24 + k));
      rd(12'h184, v); chk("R9 cleared", v, 0);
    end

    // R7: disabled bank ignores doorbells
    wr(12'h190, 32'hF7);
    ring(dbOf(3), 32'd2);
    rd(bankReg(3, 4), v); chk("R7 disabled bank", v, 0);
    chk("R8 unmatched sets flag", 32'(errFlag), 1);
    wr(12'h190, 32'hFF);
    ring(dbOf(3), 32'd2);
    rd(bankReg(3, 4), v); chk("R7 re-enabled bank", v, 32'h4);
    wr(bankReg(3, 4), 32'h4);

    // R8: out-of-range data from a clean flag
    doReset();
    chk("R1 flag after reset", 32'(errFlag), 0);
    wr(bankReg(0, 0), dbOf(0));
    wr(12'h190, 32'h1);
    ring(dbOf(0), 32'd32);
    chk("R8 data 32 flagged", 32'(errFlag), 1);
    rd(bankReg(0, 4), v); chk("R8 data 32 dropped", v, 0);
    ring(dbOf(0), 32'hFFFF_FFFF);
    rd(bankReg(0, 4), v); chk("R8 large data dropped", v, 0);
    ring(dbOf(0), 32'd31);
    rd(bankReg(0, 4), v); chk("R2 top vector accepted", v, 32'h8000_0000);
    repeat (5) tick();
    chk("R8 flag sticky", 32'(errFlag), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule